// File: doc/BRIEF.md
# Response Frame Transmit Sequencer

This block sequences the transmission of short response frames, such as clear-to-send and acknowledgement replies, that must go out a fixed interval after a reception. A command is given with two per-command options. One says whether to hold off until an external interval timer reports completion, typically a short interframe space. The other says whether the frame may only go out when the medium is idle at the moment of the send decision. When the decision is to transmit, the block pulses a start request to the PHY for one cycle. It then waits for the PHY to report that transmission has ended, and finishes straight away. It has no backoff and arms no timer after transmitting.

If the idle condition is requested and the medium is busy when the decision is taken, the frame is dropped without retry and the block reports a skipped result. An acknowledgement is normally issued with the wait option and no idle condition. A clear-to-send is issued with both options. The result code stays on the result output until the next accepted command clears it.

Top module: `rsp_tx_ctrl`

## Requirements
- R1: After reset, busy, phy_tx_start and done are 0 and result is 2'b00 (none).
- R2: A start accepted with use_wait=1 makes busy 1 on the next cycle. phy_tx_start stays 0 until timer_done is sampled high, and rises in the cycle after that sample.
- R3: A start accepted with use_wait=0 takes the send decision in the same cycle as the start, so phy_tx_start rises in the next cycle when sending is allowed.
- R4: phy_tx_start is high for exactly one cycle per command, and never goes high again before the PHY completes.
- R5: With need_idle=1, if medium_idle is 0 when the send decision is taken, phy_tx_start stays 0 and busy drops. result becomes 2'b10 (skipped) with done high for one cycle. No later retry happens, whatever the medium or timer do afterwards.
- R6: With need_idle=1 and medium_idle=1 at the decision, the frame is sent. With need_idle=0, medium_idle has no effect on the decision.
- R7: phy_tx_done sampled high while waiting for the PHY ends the command on the next cycle: busy 0, result 2'b01 (sent), done high for one cycle. No further wait follows.
- R8: result keeps its value until the next accepted start, which sets it to 2'b00 while the command runs.
- R9: start while busy is ignored. The options given with it are not taken, and the running command completes with its original options.
- R10: timer_done has no effect outside the wait stage, and phy_tx_done has no effect outside the PHY-wait stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Command strobe, taken only when not busy |
| use_wait | input | 1 | Command option: hold off until timer_done |
| need_idle | input | 1 | Command option: send only if medium idle at decision |
| timer_done | input | 1 | Post-receive interval elapsed |
| medium_idle | input | 1 | Medium is currently idle |
| phy_tx_done | input | 1 | PHY reports transmission ended |
| phy_tx_start | output | 1 | One-cycle transmit request to the PHY |
| busy | output | 1 | A command is in progress |
| done | output | 1 | One-cycle pulse when a command ends |
| result | output | RESULT_W | 00 none, 01 sent, 10 skipped |

## Verification
The embedded properties assume that phy_tx_done arrives only some cycles after the transmit request, and that start, timer_done and phy_tx_done are clean single-cycle or level strobes synchronous to clk. The directed stimulus keeps to this. It drives every input on the falling edge and returns the PHY completion at least one cycle after the request. It also deliberately places stray timer, completion and start strobes in the stages where they must be ignored, so the ignore paths are exercised without breaking those assumptions.

// File: rtl/rsp_tx_pkg.sv
package rsp_tx_pkg;

   typedef enum logic [1:0] {
      SEQ_IDLE = 2'd0,
      SEQ_WAIT = 2'd1,
      SEQ_PHY  = 2'd2
   } seq_state_t;

   localparam logic [1:0] RES_NONE = 2'b00;
   localparam logic [1:0] RES_SENT = 2'b01;
   localparam logic [1:0] RES_SKIP = 2'b10;

endpackage

// File: rtl/rsp_tx_gate.sv
module rsp_tx_gate #(
   parameter bit GATE_EN = 1'b1
) (
   input  logic need_idle,
   input  logic medium_idle,
   output logic clear_to_send
);

   generate
      if (GATE_EN) begin : g_gate
         always_comb clear_to_send = !need_idle || medium_idle;
      end else begin : g_nogate
         logic unused_gate_in;
         always_comb unused_gate_in = need_idle ^ medium_idle;
         always_comb clear_to_send  = 1'b1;
      end
   endgenerate

endmodule

// File: rtl/rsp_tx_seq.sv
module rsp_tx_seq
   import rsp_tx_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       start,
   input  logic       use_wait,
   input  logic       need_idle,
   input  logic       timer_done,
   input  logic       phy_tx_done,
   input  logic       clear_to_send,
   output logic       eff_need_idle,
   output logic       accept,
   output logic       fire,
   output logic       skip,
   output logic       finish,
   output seq_state_t state
);

   seq_state_t state_nx;
   logic       need_idle_q;
   logic       decide;

   always_comb begin
      accept        = (state == SEQ_IDLE) && start;
      eff_need_idle = (state == SEQ_IDLE) ? need_idle : need_idle_q;
      decide        = (accept && !use_wait) || ((state == SEQ_WAIT) && timer_done);
      fire          = decide && clear_to_send;
      skip          = decide && !clear_to_send;
      finish        = (state == SEQ_PHY) && phy_tx_done;
   end

   always_comb begin
      state_nx = state;
      unique case (state)
         SEQ_IDLE: if (accept) state_nx = use_wait ? SEQ_WAIT : (clear_to_send ? SEQ_PHY : SEQ_IDLE);
         SEQ_WAIT: if (timer_done) state_nx = clear_to_send ? SEQ_PHY : SEQ_IDLE;
         SEQ_PHY:  if (phy_tx_done) state_nx = SEQ_IDLE;
         default:  state_nx = SEQ_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state       <= SEQ_IDLE;
         need_idle_q <= 1'b0;
      end else begin
         state <= state_nx;
         if (accept) need_idle_q <= need_idle;
      end
   end

   // R9: a strobe while a command runs neither ends nor restarts it
   assert_ignore_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (state != SEQ_IDLE && start && !timer_done && !phy_tx_done) |=> (state == $past(state)));

   // R10: with no start, an idle sequencer stays idle whatever the other strobes do
   assert_idle_stays_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (state == SEQ_IDLE && !start) |=> (state == SEQ_IDLE));

   assert_legal_state_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (state != 2'd3));

endmodule

// File: rtl/rsp_tx_report.sv
module rsp_tx_report
   import rsp_tx_pkg::*;
#(
   parameter int RESULT_W = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                accept,
   input  logic                fire,
   input  logic                skip,
   input  logic                finish,
   output logic                phy_start_q,
   output logic                done_q,
   output logic [RESULT_W-1:0] result_q
);

   localparam logic [RESULT_W-1:0] CODE_NONE = RESULT_W'(RES_NONE);
   localparam logic [RESULT_W-1:0] CODE_SENT = RESULT_W'(RES_SENT);
   localparam logic [RESULT_W-1:0] CODE_SKIP = RESULT_W'(RES_SKIP);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phy_start_q <= 1'b0;
         done_q      <= 1'b0;
         result_q    <= CODE_NONE;
      end else begin
         phy_start_q <= fire;
         done_q      <= skip || finish;
         if (skip)        result_q <= CODE_SKIP;
         else if (finish) result_q <= CODE_SENT;
         else if (accept) result_q <= CODE_NONE;
      end
   end

endmodule

// File: rtl/rsp_tx_ctrl.sv
module rsp_tx_ctrl
   import rsp_tx_pkg::*;
#(
   parameter int RESULT_W = 2,
   parameter bit GATE_EN  = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                start,
   input  logic                use_wait,
   input  logic                need_idle,
   input  logic                timer_done,
   input  logic                medium_idle,
   input  logic                phy_tx_done,
   output logic                phy_tx_start,
   output logic                busy,
   output logic                done,
   output logic [RESULT_W-1:0] result
);

   generate
      if (RESULT_W < 2) begin : g_bad_width
         $error("rsp_tx_ctrl: RESULT_W must be at least 2");
      end
   endgenerate

   seq_state_t state;
   logic       eff_need_idle;
   logic       clear_to_send;
   logic       accept;
   logic       fire;
   logic       skip;
   logic       finish;

   rsp_tx_gate #(.GATE_EN(GATE_EN)) u_gate (
      .need_idle     (eff_need_idle),
      .medium_idle   (medium_idle),
      .clear_to_send (clear_to_send)
   );

   rsp_tx_seq u_seq (
      .clk           (clk),
      .rst_n         (rst_n),
      .start         (start),
      .use_wait      (use_wait),
      .need_idle     (need_idle),
      .timer_done    (timer_done),
      .phy_tx_done   (phy_tx_done),
      .clear_to_send (clear_to_send),
      .eff_need_idle (eff_need_idle),
      .accept        (accept),
      .fire          (fire),
      .skip          (skip),
      .finish        (finish),
      .state         (state)
   );

   rsp_tx_report #(.RESULT_W(RESULT_W)) u_report (
      .clk         (clk),
      .rst_n       (rst_n),
      .accept      (accept),
      .fire        (fire),
      .skip        (skip),
      .finish      (finish),
      .phy_start_q (phy_tx_start),
      .done_q      (done),
      .result_q    (result)
   );

   always_comb busy = (state != SEQ_IDLE);

   // R4: transmit request is a single-cycle pulse
   assert_phy_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
      phy_tx_start |=> !phy_tx_start);

   // R4: the request only appears while a command is in progress
   assert_phy_in_cmd_R4: assert property (@(posedge clk) disable iff (!rst_n)
      phy_tx_start |-> busy);

   // R5: a skipped command never requests transmission
   assert_skip_no_tx_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (done && result == RESULT_W'(RES_SKIP)) |-> (!phy_tx_start && !busy));

   // R7: completion leaves the block idle, no trailing timeout
   assert_sent_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (done && result == RESULT_W'(RES_SENT)) |-> !busy);

   // R8: result holds while idle and no start arrives
   assert_result_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !start) |=> $stable(result));

endmodule

// File: tb/rsp_tx_ctrl_tb.sv
module rsp_tx_ctrl_tb;

   localparam time CLK_PERIOD = 10ns;
   localparam int  WATCHDOG   = 100000;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       start = 1'b0;
   logic       use_wait = 1'b0;
   logic       need_idle = 1'b0;
   logic       timer_done = 1'b0;
   logic       medium_idle = 1'b0;
   logic       phy_tx_done = 1'b0;
   logic       phy_tx_start;
   logic       busy;
   logic       done;
   logic [1:0] result;

   int n_cmp = 0;
   int n_bad = 0;
   int n_cyc = 0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   rsp_tx_ctrl #(.RESULT_W(2), .GATE_EN(1'b1)) u_dut (
      .clk          (clk),
      .rst_n        (rst_n),
      .start        (start),
      .use_wait     (use_wait),
      .need_idle    (need_idle),
      .timer_done   (timer_done),
      .medium_idle  (medium_idle),
      .phy_tx_done  (phy_tx_done),
      .phy_tx_start (phy_tx_start),
      .busy         (busy),
      .done         (done),
      .result       (result)
   );

   task automatic chk(input string req, input string what, input int act, input int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
      end
   endtask

   task automatic cyc();
      @(negedge clk);
   endtask

   task automatic issue(input logic w, input logic ni);
      use_wait  = w;
      need_idle = ni;
      start     = 1'b1;
      cyc();
      start     = 1'b0;
   endtask

   task automatic pulse_timer();
      timer_done = 1'b1;
      cyc();
      timer_done = 1'b0;
   endtask

   task automatic pulse_txdone();
      phy_tx_done = 1'b1;
      cyc();
      phy_tx_done = 1'b0;
   endtask

   task automatic t_reset();
      chk("R1", "busy", busy, 0);
      chk("R1", "phy_tx_start", phy_tx_start, 0);
      chk("R1", "done", done, 0);
      chk("R1", "result", result, 0);
   endtask

   task automatic t_ack_wait();
      medium_idle = 1'b0;
      issue(1'b1, 1'b0);
      chk("R2", "busy after start", busy, 1);
      chk("R8", "result cleared", result, 0);
      chk("R2", "no early start", phy_tx_start, 0);
      for (int i = 0; i < 3; i++) begin
         cyc();
         chk("R2", "held before timer", phy_tx_start, 0);
      end
      pulse_timer();
      chk("R2", "start after timer", phy_tx_start, 1);
      chk("R6", "busy medium ignored", busy, 1);
      pulse_timer();
      chk("R4", "pulse width", phy_tx_start, 0);
      chk("R10", "timer ignored in phy wait", busy, 1);
      cyc();
      chk("R4", "no second pulse", phy_tx_start, 0);
      pulse_txdone();
      chk("R7", "busy cleared", busy, 0);
      chk("R7", "result sent", result, 1);
      chk("R7", "done pulse", done, 1);
      cyc();
      chk("R7", "done one cycle", done, 0);
      chk("R8", "result held", result, 1);
   endtask

   task automatic t_cts_busy();
      medium_idle = 1'b0;
      issue(1'b1, 1'b1);
      chk("R8", "result cleared", result, 0);
      cyc();
      pulse_timer();
      chk("R5", "no tx request", phy_tx_start, 0);
      chk("R5", "busy dropped", busy, 0);
      chk("R5", "result skipped", result, 2);
      chk("R5", "done pulse", done, 1);
      medium_idle = 1'b1;
      pulse_timer();
      for (int i = 0; i < 3; i++) begin
         chk("R5", "no retry", phy_tx_start, 0);
         cyc();
      end
      chk("R8", "skip held", result, 2);
      chk("R5", "stays idle", busy, 0);
   endtask

   task automatic t_cts_idle();
      medium_idle = 1'b1;
      issue(1'b1, 1'b1);
      cyc();
      pulse_timer();
      chk("R6", "sent when idle", phy_tx_start, 1);
      cyc();
      pulse_txdone();
      chk("R6", "result sent", result, 1);
   endtask

   task automatic t_nowait();
      medium_idle = 1'b0;
      issue(1'b0, 1'b0);
      chk("R3", "immediate start", phy_tx_start, 1);
      chk("R3", "busy", busy, 1);
      cyc();
      chk("R4", "pulse ends", phy_tx_start, 0);
      pulse_txdone();
      chk("R7", "result sent", result, 1);
      chk("R7", "done", done, 1);
   endtask

   task automatic t_nowait_skip();
      medium_idle = 1'b0;
      issue(1'b0, 1'b1);
      chk("R5", "immediate skip result", result, 2);
      chk("R5", "done", done, 1);
      chk("R5", "not busy", busy, 0);
      chk("R5", "no tx request", phy_tx_start, 0);
      cyc();
      chk("R5", "still no request", phy_tx_start, 0);
   endtask

   task automatic t_start_busy();
      medium_idle = 1'b0;
      issue(1'b1, 1'b0);
      issue(1'b0, 1'b1);
      chk("R9", "still waiting", busy, 1);
      chk("R9", "no request", phy_tx_start, 0);
      cyc();
      chk("R9", "no request later", phy_tx_start, 0);
      pulse_timer();
      chk("R9", "original options kept", phy_tx_start, 1);
      issue(1'b1, 1'b1);
      chk("R9", "phy wait kept", busy, 1);
      chk("R9", "result not touched", result, 0);
      pulse_txdone();
      chk("R9", "completes as sent", result, 1);
   endtask

   task automatic t_stray();
      timer_done  = 1'b1;
      phy_tx_done = 1'b1;
      cyc();
      timer_done  = 1'b0;
      phy_tx_done = 1'b0;
      chk("R10", "idle done", done, 0);
      chk("R10", "idle busy", busy, 0);
      chk("R10", "idle result", result, 1);
      chk("R10", "idle request", phy_tx_start, 0);
      medium_idle = 1'b1;
      issue(1'b1, 1'b0);
      pulse_txdone();
      chk("R10", "txdone in wait busy", busy, 1);
      chk("R10", "txdone in wait done", done, 0);
      pulse_timer();
      chk("R10", "request after wait", phy_tx_start, 1);
      pulse_txdone();
      chk("R10", "finished", done, 1);
   endtask

   always @(posedge clk) begin
      n_cyc++;
      if (n_cyc > WATCHDOG) begin
         n_bad++;
         $display("FAIL watchdog: actual %0d cycles expected fewer than %0d", n_cyc, WATCHDOG);
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) cyc();
      t_reset();
      rst_n = 1'b1;
      cyc();
      t_reset();
      t_ack_wait();
      t_cts_busy();
      t_cts_idle();
      t_nowait();
      t_nowait_skip();
      t_start_busy();
      t_stray();
      repeat (2) cyc();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule